// File: doc/BRIEF.md
# Redundant-Thread Servo Force Datapath

This block computes the force command of a 16-bit second-order linear position controller once per servo cycle. It has a single shared arithmetic unit: one saturating subtractor and one saturating multiplier. It runs one, two or three identical copies of the control computation as interleaved threads on that unit. A thread's subtraction is issued in the cycles where another thread is waiting on the multiplier, so each added copy costs three cycles of latency and no arithmetic hardware. With three threads, a bitwise majority of the thread results becomes the force command. With two threads, a comparator flags any disagreement. In both cases a per-thread mismatch flag is latched with the result.

A command enters on a valid/ready stream. The stream carries the desired position, the measured position and two gains in Q8 fixed point. `in_ready` is high only while the block is idle, and the block takes a command on a clock edge where `in_valid` and `in_ready` are both high. The result leaves on a second valid/ready stream. Once `out_valid` rises, the force and the flags stay frozen until the consumer raises `out_ready`. Back-pressure on the output therefore stalls the input. `inj_thread` and `inj_mask` are plain fault-injection pins. Each selected thread has the mask XORed into its result, which exercises the comparison logic without altering the arithmetic.

Top module: `rtc_thread_ctl`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `err_flags` is 0, and every thread's previous-position state is 0.
- R2: A command is taken on an edge with `in_valid` and `in_ready` both high. `in_ready` stays low from the next cycle until the result has been taken. Commands presented while `in_ready` is low change neither the result nor any state.
- R3: The force equals sat(P − V), all values 16-bit two's complement. P = sat((Kp·sat(Xd − X)) >>> 8) and V = sat((Kv·sat(X − Xprev)) >>> 8), where >>> is an arithmetic shift. Xprev is the measured position of the previous taken command.
- R4: Every subtraction and every scaled product saturates to [−32768, 32767] and never wraps.
- R5: `out_valid` rises exactly 3·N+2 cycles after the edge that takes the command, where N is the thread count: 11 cycles for N = 3.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_force` and `err_flags` stay unchanged.
- R7: With three threads, `out_force` is the bitwise majority of the three thread results. Bit i of `err_flags` is 1 exactly when thread i's result differs from `out_force`.
- R8: With two threads, `out_force` is thread 0's result. Both flag bits are 1 when the two results differ, and both are 0 otherwise.
- R9: `err_flags` is cleared on the edge that takes a command. It keeps the value latched with the result until the next command is taken.
- R10: The result of each thread whose bit is set in `inj_thread` is XORed with `inj_mask`. With no bits set, all threads agree and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Block idle, command can be taken |
| in_pos_des | input | W | Desired position, signed |
| in_pos_meas | input | W | Measured position, signed |
| in_kp | input | W | Position gain, signed Q8 |
| in_kv | input | W | Velocity gain, signed Q8 |
| out_valid | output | 1 | Force result present |
| out_ready | input | 1 | Consumer takes the result |
| out_force | output | W | Voted force command, signed |
| err_flags | output | NTHREADS | Per-thread mismatch flags |
| inj_thread | input | NTHREADS | Threads whose result is corrupted |
| inj_mask | input | W | XOR pattern applied to corrupted results |

## Verification
Plain commands with mid-range values and positive and negative errors check the arithmetic chain, and a repeated desired position with a moved measurement shows that the velocity term uses the stored previous position. Extreme operands push the subtractor and the multiplier into saturation, which separates clamping from wraparound. Injection patterns corrupt one thread, two threads with the same mask, and all three threads. These patterns separate a correct majority from a voter that follows one fixed thread or flags by comparing only against thread 0. A second instance with two threads is corrupted first on thread 1 and then on thread 0, which shows that the comparator passes thread 0 through and flags both bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int TID_W = 2;

  typedef enum logic [1:0] {
    SUB_NONE,
    SUB_ERR,
    SUB_DIF,
    SUB_OUT
  } sub_op_e;

  typedef enum logic [1:0] {
    MUL_NONE,
    MUL_POS,
    MUL_VEL
  } mul_op_e;

  typedef struct packed {
    sub_op_e          sub_op;
    logic [TID_W-1:0] sub_tid;
    mul_op_e          mul_op;
    logic [TID_W-1:0] mul_tid;
  } slot_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_VOTE,
    ST_HOLD
  } fsm_e;

endpackage

// File: rtl/rtc_sched.sv
module rtc_sched
  import rtc_pkg::*;
#(
  parameter int NTHREADS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  out_ready,
  output slot_t slot,
  output logic  idle,
  output logic  vote_en,
  output logic  out_valid
);

  localparam int LAST = 3 * NTHREADS;
  localparam int SW   = $clog2(LAST + 1);

  fsm_e          st;
  logic [SW-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      step <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st   <= ST_RUN;
          step <= '0;
        end
        ST_RUN: begin
          if (step == SW'(LAST)) st <= ST_VOTE;
          else step <= step + 1'b1;
        end
        ST_VOTE: st <= ST_HOLD;
        default: if (out_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st == ST_IDLE);
  assign vote_en   = (st == ST_VOTE);
  assign out_valid = (st == ST_HOLD);

  // Subtractor: position error and velocity difference of each thread in
  // turn, then the final difference of each thread. Multiplier: each gain
  // product one cycle after the operand it consumes was registered.
  always_comb begin
    int s;
    s    = int'(step);
    slot = '0;
    if (st == ST_RUN) begin
      if (s < 2 * NTHREADS) begin
        slot.sub_op  = (s % 2 == 1) ? SUB_DIF : SUB_ERR;
        slot.sub_tid = TID_W'(s / 2);
      end else if (s > 2 * NTHREADS) begin
        slot.sub_op  = SUB_OUT;
        slot.sub_tid = TID_W'(s - 2 * NTHREADS - 1);
      end
      if (s >= 1 && s <= 2 * NTHREADS) begin
        slot.mul_op  = ((s - 1) % 2 == 1) ? MUL_VEL : MUL_POS;
        slot.mul_tid = TID_W'((s - 1) / 2);
      end
    end
  end

endmodule

// File: rtl/rtc_alu.sv
module rtc_alu #(
  parameter int W         = 16,
  parameter int GAIN_FRAC = 8
) (
  input  logic signed [W-1:0] sub_a,
  input  logic signed [W-1:0] sub_b,
  input  logic signed [W-1:0] mul_a,
  input  logic signed [W-1:0] mul_b,
  output logic signed [W-1:0] sub_y,
  output logic signed [W-1:0] mul_y
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]     diff;
  logic signed [2*W-1:0] prod;
  logic signed [2*W-1:0] scl;

  always_comb begin
    diff = $signed({sub_a[W-1], sub_a}) - $signed({sub_b[W-1], sub_b});
    if (diff[W] != diff[W-1]) sub_y = diff[W] ? MINV : MAXV;
    else sub_y = diff[W-1:0];

    prod = $signed({{W{mul_a[W-1]}}, mul_a}) * $signed({{W{mul_b[W-1]}}, mul_b});
    scl  = prod >>> GAIN_FRAC;
    if ((&scl[2*W-1:W-1]) || !(|scl[2*W-1:W-1])) mul_y = scl[W-1:0];
    else mul_y = scl[2*W-1] ? MINV : MAXV;
  end

  always_comb begin
    AST_SUB_SAT: assert ((diff < 0) == sub_y[W-1]); // R4
    AST_MUL_SAT: assert ((scl < 0) == mul_y[W-1]);  // R4
  end

endmodule

// File: rtl/rtc_voter.sv
module rtc_voter #(
  parameter int W  = 16,
  parameter int NT = 3
) (
  input  logic [NT-1:0][W-1:0] res,
  output logic [W-1:0]         voted,
  output logic [NT-1:0]        mism
);

  generate
    if (NT == 3) begin : g_tmr
      always_comb begin
        voted = (res[0] & res[1]) | (res[0] & res[2]) | (res[1] & res[2]);
        for (int i = 0; i < 3; i++) mism[i] = (res[i] != voted);
      end
      always_comb begin
        if (res[0] == res[1] && res[1] == res[2])
          AST_UNANIMOUS: assert (mism == '0 && voted == res[0]); // R7
        if (res[0] == res[2])
          AST_PAIR_WINS: assert (voted == res[0] && !mism[0]);   // R7
      end
    end else if (NT == 2) begin : g_dmr
      always_comb begin
        voted = res[0];
        mism  = {2{res[0] != res[1]}};
      end
    end else begin : g_simplex
      always_comb begin
        voted = res[0];
        mism  = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/rtc_thread_ctl.sv
module rtc_thread_ctl
  import rtc_pkg::*;
#(
  parameter int NTHREADS  = 3,
  parameter int W         = 16,
  parameter int GAIN_FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        in_pos_des,
  input  logic [W-1:0]        in_pos_meas,
  input  logic [W-1:0]        in_kp,
  input  logic [W-1:0]        in_kv,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_force,
  output logic [NTHREADS-1:0] err_flags,
  input  logic [NTHREADS-1:0] inj_thread,
  input  logic [W-1:0]        inj_mask
);

  localparam int LAT = 3 * NTHREADS + 2;
  localparam int LCW = $clog2(LAT + 1) + 1;

  slot_t slot;
  logic  idle, vote_en, hold, accept;

  assign accept    = in_valid && idle;
  assign in_ready  = idle;
  assign out_valid = hold;

  rtc_sched #(.NTHREADS(NTHREADS)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .out_ready (out_ready),
    .slot      (slot),
    .idle      (idle),
    .vote_en   (vote_en),
    .out_valid (hold)
  );

  // Command captured once, shared by all threads.
  logic signed [W-1:0] des_q, meas_q, kp_q, kv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      des_q  <= '0;
      meas_q <= '0;
      kp_q   <= '0;
      kv_q   <= '0;
    end else if (accept) begin
      des_q  <= in_pos_des;
      meas_q <= in_pos_meas;
      kp_q   <= in_kp;
      kv_q   <= in_kv;
    end
  end

  // Per-thread working registers and private previous-position state.
  logic signed [W-1:0] perr_r [NTHREADS];
  logic signed [W-1:0] vdif_r [NTHREADS];
  logic signed [W-1:0] pterm_r[NTHREADS];
  logic signed [W-1:0] vterm_r[NTHREADS];
  logic signed [W-1:0] res_r  [NTHREADS];
  logic signed [W-1:0] prev_r [NTHREADS];

  logic signed [W-1:0] sub_a, sub_b, mul_a, mul_b, sub_y, mul_y;
  logic signed [W-1:0] s_prev, s_pt, s_vt, m_perr, m_vdif;

  always_comb begin
    s_prev = '0;
    s_pt   = '0;
    s_vt   = '0;
    m_perr = '0;
    m_vdif = '0;
    for (int t = 0; t < NTHREADS; t++) begin
      if (slot.sub_tid == TID_W'(t)) begin
        s_prev = prev_r[t];
        s_pt   = pterm_r[t];
        s_vt   = vterm_r[t];
      end
      if (slot.mul_tid == TID_W'(t)) begin
        m_perr = perr_r[t];
        m_vdif = vdif_r[t];
      end
    end

    case (slot.sub_op)
      SUB_ERR: begin sub_a = des_q;  sub_b = meas_q; end
      SUB_DIF: begin sub_a = meas_q; sub_b = s_prev; end
      SUB_OUT: begin sub_a = s_pt;   sub_b = s_vt;   end
      default: begin sub_a = '0;     sub_b = '0;     end
    endcase

    case (slot.mul_op)
      MUL_POS: begin mul_a = kp_q; mul_b = m_perr; end
      MUL_VEL: begin mul_a = kv_q; mul_b = m_vdif; end
      default: begin mul_a = '0;   mul_b = '0;     end
    endcase
  end

  rtc_alu #(.W(W), .GAIN_FRAC(GAIN_FRAC)) u_alu (
    .sub_a (sub_a),
    .sub_b (sub_b),
    .mul_a (mul_a),
    .mul_b (mul_b),
    .sub_y (sub_y),
    .mul_y (mul_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHREADS; t++) begin
        perr_r[t]  <= '0;
        vdif_r[t]  <= '0;
        pterm_r[t] <= '0;
        vterm_r[t] <= '0;
        res_r[t]   <= '0;
        prev_r[t]  <= '0;
      end
    end else begin
      for (int t = 0; t < NTHREADS; t++) begin
        if (slot.sub_tid == TID_W'(t)) begin
          case (slot.sub_op)
            SUB_ERR: perr_r[t] <= sub_y;
            SUB_DIF: vdif_r[t] <= sub_y;
            SUB_OUT: res_r[t]  <= sub_y ^ (inj_thread[t] ? inj_mask : '0);
            default: ;
          endcase
        end
        if (slot.mul_tid == TID_W'(t)) begin
          case (slot.mul_op)
            MUL_POS: pterm_r[t] <= mul_y;
            MUL_VEL: vterm_r[t] <= mul_y;
            default: ;
          endcase
        end
        if (vote_en) prev_r[t] <= meas_q;
      end
    end
  end

  logic [NTHREADS-1:0][W-1:0] res_pk;
  logic [W-1:0]               voted;
  logic [NTHREADS-1:0]        mism;

  always_comb begin
    for (int t = 0; t < NTHREADS; t++) res_pk[t] = res_r[t];
  end

  rtc_voter #(.W(W), .NT(NTHREADS)) u_voter (
    .res   (res_pk),
    .voted (voted),
    .mism  (mism)
  );

  logic [W-1:0]        force_q;
  logic [NTHREADS-1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= '0;
      err_q   <= '0;
    end else if (accept) begin
      err_q <= '0;
    end else if (vote_en) begin
      force_q <= voted;
      err_q   <= mism;
    end
  end

  assign out_force = force_q;
  assign err_flags = err_q;

  // Cycle count since the last taken command, for the latency check.
  logic [LCW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (!idle && lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == LCW'(LAT)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_force) && $stable(err_flags))); // R6

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> err_flags == '0); // R9

endmodule

// File: tb/rtc_thread_ctl_test.sv
module rtc_thread_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int NT  = 3;
  localparam int LAT = 3 * NT + 2;

  logic clk = 0;
  logic rst_n = 0;

  logic          in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [W-1:0]  in_pos_des = '0, in_pos_meas = '0, in_kp = '0, in_kv = '0;
  logic [W-1:0]  out_force, inj_mask = '0;
  logic [NT-1:0] err_flags, inj_thread = '0;

  logic          d_in_valid = 0, d_in_ready, d_out_valid;
  logic [W-1:0]  d_des = '0, d_meas = '0, d_kp = '0, d_kv = '0, d_force, d_mask = '0;
  logic [1:0]    d_err, d_inj = '0;

  rtc_thread_ctl #(.NTHREADS(NT), .W(W), .GAIN_FRAC(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pos_des(in_pos_des), .in_pos_meas(in_pos_meas), .in_kp(in_kp), .in_kv(in_kv),
    .out_valid(out_valid), .out_ready(out_ready), .out_force(out_force),
    .err_flags(err_flags), .inj_thread(inj_thread), .inj_mask(inj_mask)
  );

  rtc_thread_ctl #(.NTHREADS(2), .W(W), .GAIN_FRAC(8)) uut_dual (
    .clk(clk), .rst_n(rst_n), .in_valid(d_in_valid), .in_ready(d_in_ready),
    .in_pos_des(d_des), .in_pos_meas(d_meas), .in_kp(d_kp), .in_kv(d_kv),
    .out_valid(d_out_valid), .out_ready(1'b1), .out_force(d_force),
    .err_flags(d_err), .inj_thread(d_inj), .inj_mask(d_mask)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int     n_tests = 0, n_fail = 0;
  longint cyc = 0, acc_cyc = 0;
  longint mprev = 0, dprev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Control law from R3 with the clamping of R4.
  function automatic longint law(input longint xd, input longint x, input longint kp,
                                 input longint kv, input longint pv);
    longint e, d, p, q;
    e = sat16(xd - x);
    d = sat16(x - pv);
    p = sat16((kp * e) >>> 8);
    q = sat16((kv * d) >>> 8);
    return sat16(p - q);
  endfunction

  typedef struct {
    logic [W-1:0]  fv;
    logic [NT-1:0] ev;
    string         tag;
  } exp_t;

  exp_t sbq[$];

  // Monitor: latency, hold stability and scoreboard comparison.
  logic          prev_ov = 0, hold_seen = 0;
  logic [W-1:0]  hold_f;
  logic [NT-1:0] hold_e;
  exp_t          ex_m;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !prev_ov)
        chk(cyc - acc_cyc == LAT, "R5", "result latency", cyc - acc_cyc, LAT);
      if (out_valid && hold_seen)
        chk(out_force == hold_f && err_flags == hold_e, "R6", "held result",
            $signed(out_force), $signed(hold_f));
      if (out_valid && !out_ready) begin
        hold_seen = 1;
        hold_f    = out_force;
        hold_e    = err_flags;
      end else begin
        hold_seen = 0;
      end
      if (out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          chk(0, "R2", "result without command", $signed(out_force), 0);
        end else begin
          ex_m = sbq.pop_front();
          chk(out_force == ex_m.fv, ex_m.tag, "force", $signed(out_force), $signed(ex_m.fv));
          chk(err_flags == ex_m.ev, "R7", "mismatch flags", err_flags, ex_m.ev);
        end
      end
      prev_ov = out_valid;
    end
  end

  // Driver: computes the expected item, pushes it and runs one command.
  task automatic send(input longint xd, input longint x, input longint kp, input longint kv,
                      input logic [NT-1:0] inj, input logic [W-1:0] mask,
                      input string tag, input bit junk, input bit bp);
    longint       f;
    logic [W-1:0] r[NT];
    logic [W-1:0] v;
    exp_t         ex;
    f = law(xd, x, kp, kv, mprev);
    mprev = x;
    for (int t = 0; t < NT; t++) r[t] = W'(f) ^ (inj[t] ? mask : '0);
    v = (r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]);
    ex.fv = v;
    for (int t = 0; t < NT; t++) ex.ev[t] = (r[t] != v);
    ex.tag = tag;
    sbq.push_back(ex);

    @(posedge clk); #1;
    in_pos_des  = W'(xd);
    in_pos_meas = W'(x);
    in_kp       = W'(kp);
    in_kv       = W'(kv);
    inj_thread  = inj;
    inj_mask    = mask;
    in_valid    = 1;
    if (bp) out_ready = 0;
    @(posedge clk); #1;
    in_valid = 0;
    acc_cyc  = cyc;
    @(negedge clk);
    chk(!in_ready, "R2", "in_ready after take", in_ready, 0);
    chk(err_flags == '0, "R9", "flags cleared on take", err_flags, 0);
    if (junk) begin
      @(posedge clk); #1;
      in_valid    = 1;
      in_pos_des  = W'(-12345);
      in_pos_meas = W'(777);
      in_kp       = 16'h7fff;
      repeat (3) @(posedge clk);
      #1 in_valid = 0;
    end
    if (bp) begin
      do @(negedge clk); while (!out_valid);
      repeat (3) @(negedge clk);
      chk(!in_ready, "R2", "in_ready while result held", in_ready, 0);
      @(posedge clk); #1;
      out_ready = 1;
    end
    do @(negedge clk); while (!(out_valid && out_ready));
    @(negedge clk);
    chk(err_flags == ex.ev, "R9", "flags held after take", err_flags, ex.ev);
    @(posedge clk); #1;
    inj_thread = '0;
    inj_mask   = '0;
  endtask

  // Two-thread instance: output follows thread 0, both flags on mismatch.
  task automatic dual_run(input longint xd, input longint x, input longint kp, input longint kv,
                          input logic [1:0] inj, input logic [W-1:0] mask);
    longint       f;
    logic [W-1:0] r0, r1;
    logic [1:0]   ee;
    f  = law(xd, x, kp, kv, dprev);
    dprev = x;
    r0 = W'(f) ^ (inj[0] ? mask : '0);
    r1 = W'(f) ^ (inj[1] ? mask : '0);
    ee = (r0 != r1) ? 2'b11 : 2'b00;
    @(posedge clk); #1;
    d_des      = W'(xd);
    d_meas     = W'(x);
    d_kp       = W'(kp);
    d_kv       = W'(kv);
    d_inj      = inj;
    d_mask     = mask;
    d_in_valid = 1;
    @(posedge clk); #1;
    d_in_valid = 0;
    do @(negedge clk); while (!d_out_valid);
    chk(d_force == r0, "R8", "two-thread force", $signed(d_force), $signed(r0));
    chk(d_err == ee, "R8", "two-thread flags", d_err, ee);
    @(posedge clk); #1;
    d_inj  = '0;
    d_mask = '0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(err_flags == '0, "R1", "flags after reset", err_flags, 0);

    send(1000, 200, 256, 128, '0, '0, "R3", 0, 0);
    send(1000, 300, 256, 128, '0, '0, "R3", 0, 0);
    send(-500, 400, 512, 64, '0, '0, "R2", 1, 0);
    send(32767, -32768, 32767, 256, '0, '0, "R4", 0, 0);
    send(-32768, 32767, 32767, 32767, '0, '0, "R4", 0, 0);
    send(1200, -50, 300, 200, 3'b010, 16'h0010, "R10", 0, 0);
    send(1200, -40, 300, 200, 3'b101, 16'h8000, "R7", 0, 0);
    send(-700, 90, 384, 100, 3'b111, 16'h0f0f, "R10", 0, 0);
    send(2500, 1500, 200, 300, 3'b001, 16'h0003, "R6", 0, 1);
    send(0, 0, 256, 256, '0, '0, "R3", 0, 0);

    dual_run(1000, 200, 256, 128, 2'b00, '0);
    dual_run(900, 250, 256, 128, 2'b10, 16'h0100);
    dual_run(-300, 100, 512, 64, 2'b01, 16'h0001);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R2", "results still expected", sbq.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R5 watchdog: actual %0d cycles expected fewer", 20000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule